// File: doc/BRIEF.md
# Daisy-Chain Serial Configuration Shifter

This block sits at the serial configuration input of one device in a chain. Configuration bits arrive on `din` and are sampled on the rising edge of `clk`. The block counts the bits it accepts until it has taken a programmed number of them, `frame_len`. It then raises `done` and keeps it high until reset.

The output `dout` is always launched on the falling edge of `clk`, so the next device, which samples on the rising edge, sees half a clock period of setup and hold. The meaning of `dout` depends on `express_mode`:

- **Pass mode** (`express_mode` = 0): `dout` stays high while the frame is being filled. After the frame is complete, `dout` repeats every later input bit, so the next device in the chain receives its own frame.
- **Express mode** (`express_mode` = 1): bits are accepted only while `chain_en` is high. `dout` works as the select line of the next device. It stays low until this device's frame is complete and is high afterwards.

Top module: `cfg_chain_shifter`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears its state. After reset, `done` is 0 and `dout` is 1 (both encodings active-high).
- R2: A bit is accepted on a rising edge of `clk` only. Each accepted bit advances the frame count by one.
- R3: `dout` changes only on a falling edge of `clk`. At every rising edge it keeps the value launched at the previous falling edge.
- R4: In pass mode (`express_mode` = 0), `dout` is 1 until `done` is set. This includes the falling edge right after the rising edge that completes the frame.
- R5: `done` goes to 1 on the rising edge at which the number of accepted bits reaches `frame_len`. It then stays 1 until reset.
- R6: In pass mode, once `done` is 1, each bit sampled at a rising edge is driven on `dout` from the following falling edge.
- R7: In express mode (`express_mode` = 1), a rising edge with `chain_en` = 0 accepts nothing. The count does not advance, which delays `done`.
- R8: In express mode, `dout` at each falling edge takes the current value of `done`. It is 0 while the frame is incomplete and 1 afterwards.
- R9: A `frame_len` of 0 behaves like 1: the first accepted bit completes the frame.
- R10: In pass mode `chain_en` has no effect. Every rising edge accepts a bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock. Input is sampled on the rising edge and output is launched on the falling edge. |
| rst_n | input | 1 | Synchronous active-low reset. |
| express_mode | input | 1 | 0 selects pass mode; 1 selects express mode. |
| chain_en | input | 1 | Serial enable from the upstream device. Used in express mode only. |
| frame_len | input | CNT_W | Number of bits this device keeps. |
| din | input | 1 | Serial configuration data in. |
| dout | output | 1 | Pass mode: idle-high repeat of later bits. Express mode: enable for the next device. |
| done | output | 1 | High once this device's frame is complete. |

## Verification
Pass mode is driven with a short fixed frame followed by alternating and irregular trailing bits. A repeated pattern could not show whether the forwarded bit is late or early by one cycle; these patterns can. Express mode is driven with `chain_en` gaps, so a block that counts while disabled completes its frame visibly early. A zero-length frame and a long pseudo-random stream cover the lower bound and a larger count. In pass mode, `chain_en` is toggled throughout to show that it is ignored there. Each step is checked both just after the rising edge and just after the falling edge, which separates a correct falling-edge launch from a rising-edge one.

// File: rtl/cfg_chain_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the chain shifter.
// Assumes: express_mode is driven as a single bit, 1 = express.
package cfg_chain_pkg;

    typedef enum logic {
        MODE_PASS    = 1'b0,
        MODE_EXPRESS = 1'b1
    } chain_mode_e;

    // Decide whether the current rising edge takes a bit.
    function automatic logic bit_accepted(input chain_mode_e mode, input logic enable);
        return (mode == MODE_PASS) ? 1'b1 : enable;
    endfunction

endpackage

// File: rtl/cfg_bit_counter.sv
`timescale 1ns/1ps
// Counts accepted bits up to frame_len and holds a sticky done flag.
// Assumes: frame_len is held steady during a frame; 0 is treated as 1.
module cfg_bit_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [CNT_W-1:0] frame_len,
    output logic             done
);
    localparam int NEXT_W = CNT_W + 1;

    logic [CNT_W-1:0]  cnt_q;
    logic [NEXT_W-1:0] cnt_plus;
    logic              last_bit;

    // Next count and frame-completion compare.
    always_comb begin
        cnt_plus = {1'b0, cnt_q} + NEXT_W'(1);
        last_bit = (cnt_plus >= {1'b0, frame_len});
    end

    // Advance while the frame is open; set done on the final bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            done  <= 1'b0;
        end else if (accept && !done) begin
            cnt_q <= cnt_plus[CNT_W-1:0];
            if (last_bit) begin
                done <= 1'b1;
            end
        end
    end

    // R5: once set, done stays set until reset.
    a_r5_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    // R7: an edge that accepts nothing leaves the count alone.
    a_r7_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(cnt_q));

    // R9: a zero length completes on the first accepted bit.
    a_r9_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_len == '0 && accept) |=> done);
endmodule

// File: rtl/cfg_capture_stage.sv
`timescale 1ns/1ps
// Rising-edge capture of the bit to repeat downstream.
// Assumes: done is the registered flag from the counter; a bit is repeated
// only when the frame was already complete before this edge.
module cfg_capture_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic done,
    output logic fwd_bit
);
    // Hold the incoming bit after completion, otherwise the idle-high level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_bit <= 1'b1;
        end else begin
            fwd_bit <= done ? din : 1'b1;
        end
    end
endmodule

// File: rtl/cfg_launch_stage.sv
`timescale 1ns/1ps
// Falling-edge output register: selects either the repeated data or the
// downstream enable, depending on the mode.
// Assumes: fwd_bit and done are stable at the falling edge, since both are
// written on rising edges.
module cfg_launch_stage
    import cfg_chain_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  chain_mode_e mode,
    input  logic        done,
    input  logic        fwd_bit,
    output logic        dout
);
    // Launch the output half a cycle after capture.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            dout <= 1'b1;
        end else begin
            dout <= (mode == MODE_EXPRESS) ? done : fwd_bit;
        end
    end

    // R8: in express mode the output follows the done flag.
    a_r8_express_enable: assert property (@(negedge clk) disable iff (!rst_n)
        (mode == MODE_EXPRESS) |=> (dout == $past(done)));

    // R4: in pass mode the output idles high until completion.
    a_r4_idle_high: assert property (@(negedge clk) disable iff (!rst_n)
        (mode == MODE_PASS && !done) |=> dout);
endmodule

// File: rtl/cfg_chain_shifter.sv
`timescale 1ns/1ps
// Top of the daisy-chain serial configuration shifter.
// Captures on the rising edge of clk and launches dout on the falling edge.
// Assumes: rst_n is synchronous, active-low, and held for at least one full
// clock period.
module cfg_chain_shifter
    import cfg_chain_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             express_mode,
    input  logic             chain_en,
    input  logic [CNT_W-1:0] frame_len,
    input  logic             din,
    output logic             dout,
    output logic             done
);
    chain_mode_e mode;
    logic        accept;
    logic        fwd_bit;

    // Decode the mode and the per-edge accept.
    always_comb begin
        mode   = chain_mode_e'(express_mode);
        accept = bit_accepted(mode, chain_en);
    end

    cfg_bit_counter #(.CNT_W(CNT_W)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .frame_len (frame_len),
        .done      (done)
    );

    cfg_capture_stage u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (din),
        .done    (done),
        .fwd_bit (fwd_bit)
    );

    cfg_launch_stage u_launch (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .done    (done),
        .fwd_bit (fwd_bit),
        .dout    (dout)
    );

    // R6: in pass mode after completion, a captured bit appears at the next
    // falling edge.
    a_r6_repeat: assert property (@(negedge clk) disable iff (!rst_n)
        (!express_mode && $past(done)) |-> ##1 (dout == $past(fwd_bit)));
endmodule

// File: tb/cfg_chain_shifter_bench.sv
`timescale 1ns/1ps
module cfg_chain_shifter_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         express_mode = 1'b0;
    logic         chain_en = 1'b0;
    logic [W-1:0] frame_len = '0;
    logic         din = 1'b1;
    logic         dout;
    logic         done;

    int n_tests = 0;
    int n_fail  = 0;

    // Behavioural reference state.
    int m_cnt;
    bit m_done;
    bit m_dout;
    bit fwd_q[$];

    always #4 clk = ~clk;

    cfg_chain_shifter #(.CNT_W(W)) u_cfg_chain_shifter (
        .clk(clk), .rst_n(rst_n), .express_mode(express_mode), .chain_en(chain_en),
        .frame_len(frame_len), .din(din), .dout(dout), .done(done)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // R1: hold reset across two rising edges and one falling edge.
    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        #1;
        m_cnt = 0; m_done = 0; m_dout = 1; fwd_q.delete(); fwd_q.push_back(1'b1);
        chk("R1 dout", dout, 1'b1);
        chk("R1 done", done, 1'b0);
        rst_n = 1'b1;
    endtask

    // One clock of stimulus; checks after each edge.
    task automatic step(input bit d, input bit e);
        bit    acc;
        bit    old_done;
        string tag;
        din = d; chain_en = e;
        @(posedge clk);
        #1;
        acc = !express_mode || e;
        old_done = m_done;
        if (acc && !m_done) begin
            m_cnt++;
            if (m_cnt >= int'(frame_len)) m_done = 1;
        end
        void'(fwd_q.pop_front());
        fwd_q.push_back(old_done ? d : 1'b1);
        if (frame_len == 0) tag = "R9";
        else if (express_mode && !e) tag = "R7";
        else if (!express_mode && !e) tag = "R10";
        else tag = "R2 R5";
        chk(tag, done, m_done);
        chk("R3", dout, m_dout);
        @(negedge clk);
        #1;
        m_dout = express_mode ? m_done : fwd_q[0];
        if (express_mode) tag = "R8";
        else if (old_done) tag = "R6";
        else tag = "R4";
        chk(tag, dout, m_dout);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int lfsr;
        bit [12:0] pat;
        // Pass mode, frame of 5, chain_en toggled (R10), then trailing data (R6).
        express_mode = 0; frame_len = 5;
        do_reset();
        pat = 13'b1_0100_1100_1101;
        for (int i = 0; i < 13; i++) step(pat[i], i[0]);
        // Express mode, frame of 4, with enable gaps (R7, R8).
        express_mode = 1; frame_len = 4;
        do_reset();
        pat = 13'b1_1001_1010_1101;
        for (int i = 0; i < 13; i++) step(i[1], pat[i]);
        // Zero-length frame (R9).
        express_mode = 0; frame_len = 0;
        do_reset();
        for (int i = 0; i < 6; i++) step(i[0] ^ i[2], 1'b1);
        // Express mode with a zero-length frame.
        express_mode = 1; frame_len = 0;
        do_reset();
        step(1'b0, 1'b0); step(1'b0, 1'b1); step(1'b1, 1'b0);
        // Long pseudo-random stream in pass mode.
        express_mode = 0; frame_len = 37;
        do_reset();
        lfsr = 32'h1ACE;
        for (int i = 0; i < 80; i++) begin
            lfsr = (lfsr << 1) | (((lfsr >> 15) ^ (lfsr >> 13) ^ (lfsr >> 12) ^ (lfsr >> 10)) & 1);
            lfsr = lfsr & 32'hFFFF;
            step(lfsr[0], lfsr[3]);
        end
        // Reset after completion clears done (R1, R5).
        do_reset();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule